// File: doc/BRIEF.md
# Write Strobe Contiguous-Run Splitter

This block sits between a wide bus write port and a byte-addressable store that accepts variable-length byte writes. It takes one data word with its per-byte strobe and the word's address. It then issues one write command for each unbroken stretch of enabled byte lanes. A single lane therefore never turns into its own command unless it is isolated. Lane i carries byte i of the word in little-endian order. The lowest run leaves first. Each command carries the byte address of the run's first lane, the run length in bytes, and the run's bytes packed down to byte 0 of the command data.

Commands leave one per cycle on a valid/ready handshake. The downstream side may flag an error alongside any command it accepts. Those flags are merged into one sticky error that is presented together with a one-cycle done pulse after the word's last command. The block takes a new word only after that pulse. A strobe-select input lets a caller that has no strobe treat the whole word as enabled. The lane count, address width and the structure of the byte-packing network are parameters.

Top module: `strb_run_splitter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `done` and `done_err` are 0.
- R2: A word is taken on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the cycle after acceptance up to and including the `done` cycle, and it returns to 1 on the cycle after `done`. `in_ready` and `out_valid` are never 1 together.
- R3: For each maximal group of adjacent enabled lanes, exactly one command is issued, with `out_len` equal to the group's lane count. A group that reaches the top lane is closed at the word's end. Commands leave in ascending lane order, and each one starts at least one lane above the end of the previous one.
- R4: `out_addr` equals the word address with its low log2(LANES) bits forced to zero, plus the index of the run's first lane.
- R5: Byte j of `out_data` (bits 8j+7..8j) equals data lane (first lane + j) for j < `out_len`. Every byte at or above `out_len` is zero.
- R6: When `in_strb_use` is 0, `in_strb` is ignored and the word yields exactly one command with lane 0 as its first lane and `out_len` equal to LANES.
- R7: A word whose applied strobe is all zeros yields no command. `done` is then asserted on the cycle after acceptance.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, and `out_addr`, `out_len` and `out_data` are unchanged.
- R9: `done` is a one-cycle pulse. It is asserted on the cycle after the handshake of the word's last command, and `out_valid` is 0 while it is high.
- R10: `done_err` is 1 only while `done` is 1. In that cycle it is 1 exactly when `cmd_err` was 1 on at least one command handshake of the current word. Flags from earlier words do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word |
| in_addr | input | ADDR_W | Word address; low log2(LANES) bits ignored |
| in_data | input | 8*LANES | Word data, lane i in bits 8i+7..8i |
| in_strb | input | LANES | Per-lane enable, bit i for lane i |
| in_strb_use | input | 1 | 1: apply `in_strb`; 0: all lanes enabled |
| out_valid | output | 1 | Command offered |
| out_ready | input | 1 | Downstream takes the command |
| out_addr | output | ADDR_W | Byte address of the run's first lane |
| out_len | output | clog2(LANES+1) | Run length in bytes (1..LANES) |
| out_data | output | 8*LANES | Run bytes packed from byte 0, zero above the run |
| cmd_err | input | 1 | Downstream error, sampled on command handshake |
| done | output | 1 | One-cycle pulse after a word's last command |
| done_err | output | 1 | Sticky error of the finished word, valid with `done` |

## Verification
On every cycle, the assertions check the handshake rules: the payload holds while stalled, `in_ready` and `out_valid` never overlap, `done` is a lone pulse that reopens the input, and `done_err` appears only with it. They also check the shape of each command: its length is within the word, the run fits inside the word, and each run starts strictly above the end of the previous one. Other properties need the bench's reference model, fed with chosen strobe patterns. These are that every run is maximal, that the byte packing and address offset are correct, that the all-zero and no-strobe cases behave as required, and that the error flag tracks exactly the flagged handshakes of one word.

// File: rtl/strb_run_pkg.sv
package strb_run_pkg;

   // Control sequencing of one word through the splitter
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // waiting for a word
      ST_EMIT = 2'd1,   // issuing runs
      ST_FIN  = 2'd2    // done pulse
   } split_state_e;

   // Packing network variants
   localparam int ALIGN_SHIFT = 0;
   localparam int ALIGN_MUX   = 1;

endpackage

// File: rtl/strb_run_finder.sv
// Locates the lowest enabled lane in a pending-lane mask and measures
// the unbroken run of enabled lanes that begins there.
module strb_run_finder #(
   parameter int LANES = 8,
   localparam int IDX_W = $clog2(LANES),
   localparam int LEN_W = $clog2(LANES + 1)
) (
   input  logic [LANES-1:0] pend,
   output logic             any,
   output logic [IDX_W-1:0] first,
   output logic [LEN_W-1:0] len,
   output logic [LANES-1:0] run_lanes
);

   logic stop;

   always_comb begin
      any   = 1'b0;
      first = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!any && pend[i]) begin
            any   = 1'b1;
            first = IDX_W'(i);
         end
      end

      run_lanes = '0;
      len       = '0;
      stop      = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (any && !stop && (i >= int'(first))) begin
            if (pend[i]) begin
               run_lanes[i] = 1'b1;
               len          = len + LEN_W'(1);
            end else begin
               stop = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/strb_run_aligner.sv
// Packs the bytes of a run down to byte 0 and zeroes bytes past its end.
module strb_run_aligner #(
   parameter int LANES = 8,
   parameter int IMPL  = 0,
   localparam int IDX_W  = $clog2(LANES),
   localparam int LEN_W  = $clog2(LANES + 1),
   localparam int DATA_W = LANES * 8
) (
   input  logic [DATA_W-1:0] word,
   input  logic [IDX_W-1:0]  first,
   input  logic [LEN_W-1:0]  len,
   output logic [DATA_W-1:0] packed_data
);

   generate
      if (IMPL == strb_run_pkg::ALIGN_SHIFT) begin : g_shift
         logic [DATA_W-1:0] shifted;
         assign shifted = word >> {first, 3'b000};
         for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign packed_data[j*8 +: 8] = (LEN_W'(j) < len) ? shifted[j*8 +: 8] : 8'h00;
         end
      end else begin : g_mux
         for (genvar j = 0; j < LANES; j++) begin : g_lane
            logic [7:0] pick;
            always_comb begin
               pick = 8'h00;
               for (int k = 0; k < LANES; k++) begin
                  if ((k == int'(first) + j) && (j < int'(len))) begin
                     pick = word[k*8 +: 8];
                  end
               end
            end
            assign packed_data[j*8 +: 8] = pick;
         end
      end
   endgenerate

endmodule

// File: rtl/strb_run_splitter.sv
// Splits one strobed data word into byte-run write commands, one per
// maximal span of adjacent enabled lanes, lowest span first.
module strb_run_splitter
   import strb_run_pkg::*;
#(
   parameter int LANES      = 8,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_IMPL = ALIGN_SHIFT
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [ADDR_W-1:0]            in_addr,
   input  logic [LANES*8-1:0]           in_data,
   input  logic [LANES-1:0]             in_strb,
   input  logic                         in_strb_use,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [ADDR_W-1:0]            out_addr,
   output logic [$clog2(LANES+1)-1:0]   out_len,
   output logic [LANES*8-1:0]           out_data,
   input  logic                         cmd_err,
   output logic                         done,
   output logic                         done_err
);

   localparam int IDX_W  = $clog2(LANES);
   localparam int LEN_W  = $clog2(LANES + 1);
   localparam int DATA_W = LANES * 8;

   // Elaboration-time parameter checks
   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed log2(LANES)");
      end
      if (ALIGN_IMPL != ALIGN_SHIFT && ALIGN_IMPL != ALIGN_MUX) begin : g_bad_impl
         $error("ALIGN_IMPL selects an unknown packing network");
      end
   endgenerate

   split_state_e        state_q;
   logic [LANES-1:0]    pend_q;
   logic [ADDR_W-1:0]   base_q;
   logic [DATA_W-1:0]   data_q;
   logic                err_q;

   logic                run_any;
   logic [IDX_W-1:0]    run_first;
   logic [LEN_W-1:0]    run_len;
   logic [LANES-1:0]    run_lanes;
   logic [LANES-1:0]    take_mask;
   logic [LANES-1:0]    pend_after;
   logic                accept;
   logic                fire;

   strb_run_finder #(.LANES(LANES)) u_finder (
      .pend      (pend_q),
      .any       (run_any),
      .first     (run_first),
      .len       (run_len),
      .run_lanes (run_lanes)
   );

   strb_run_aligner #(.LANES(LANES), .IMPL(ALIGN_IMPL)) u_aligner (
      .word        (data_q),
      .first       (run_first),
      .len         (run_len),
      .packed_data (out_data)
   );

   assign take_mask  = in_strb_use ? in_strb : {LANES{1'b1}};
   assign pend_after = pend_q & ~run_lanes;

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_EMIT) && run_any;
   assign accept    = in_valid && in_ready;
   assign fire      = out_valid && out_ready;

   assign out_addr  = base_q | ADDR_W'(run_first);
   assign out_len   = run_len;
   assign done      = (state_q == ST_FIN);
   assign done_err  = (state_q == ST_FIN) && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         base_q  <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  pend_q  <= take_mask;
                  base_q  <= {in_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
                  data_q  <= in_data;
                  err_q   <= 1'b0;
                  state_q <= (take_mask == '0) ? ST_FIN : ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (fire) begin
                  pend_q <= pend_after;
                  if (cmd_err) begin
                     err_q <= 1'b1;
                  end
                  if (pend_after == '0) begin
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/strb_run_splitter_chk.sv
// Protocol and shape checks for the run splitter, bound to every instance.
module strb_run_splitter_chk #(
   parameter int LANES  = 8,
   parameter int ADDR_W = 32,
   localparam int IDX_W = $clog2(LANES),
   localparam int LEN_W = $clog2(LANES + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [ADDR_W-1:0]    out_addr,
   input logic [LEN_W-1:0]     out_len,
   input logic [LANES*8-1:0]   out_data,
   input logic                 done,
   input logic                 done_err
);

   logic [IDX_W-1:0] lane0;
   assign lane0 = out_addr[IDX_W-1:0];

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_data))) // R8
      else $error("payload moved while stalled");

   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid)) // R2
      else $error("input open while commands pending");

   AST_DONE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> in_ready) // R2
      else $error("input not reopened after done");

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) // R9
      else $error("done longer than one cycle");

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid) // R9
      else $error("command offered during done");

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> done) // R10
      else $error("error flag outside done");

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len != '0 && int'(out_len) <= LANES)) // R3
      else $error("run length out of range");

   AST_RUN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(lane0) + int'(out_len) <= LANES)) // R4
      else $error("run spills past word end");

   AST_RUN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=>
         (!out_valid || int'(lane0) > int'($past(lane0)) + int'($past(out_len)))) // R3
      else $error("runs out of order or adjacent");

endmodule

bind strb_run_splitter strb_run_splitter_chk #(
   .LANES  (LANES),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .out_len   (out_len),
   .out_data  (out_data),
   .done      (done),
   .done_err  (done_err)
);

// File: tb/strb_run_splitter_tb.sv
module strb_run_splitter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 8;
   localparam int ADDR_W     = 16;
   localparam int LEN_W      = $clog2(LANES + 1);
   localparam int IDX_W      = $clog2(LANES);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_ready;
   logic [ADDR_W-1:0]  in_addr = '0;
   logic [63:0]        in_data = '0;
   logic [LANES-1:0]   in_strb = '0;
   logic               in_strb_use = 1'b1;
   logic               out_valid;
   logic               out_ready = 1'b1;
   logic [ADDR_W-1:0]  out_addr;
   logic [LEN_W-1:0]   out_len;
   logic [63:0]        out_data;
   logic               cmd_err = 1'b0;
   logic               done;
   logic               done_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   strb_run_splitter #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .in_data(in_data), .in_strb(in_strb), .in_strb_use(in_strb_use),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_len(out_len), .out_data(out_data), .cmd_err(cmd_err),
      .done(done), .done_err(done_err)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int ready_mode = 0;   // 0 always, 1 random, 2 slow
   int err_mode   = 0;   // 0 none, 1 random
   int cyc        = 0;
   int word_valid_cycles = 0;
   int first_len = -1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct {
      logic [ADDR_W-1:0] a;
      int                l;
      logic [63:0]       d;
   } cmd_t;

   cmd_t q[$];
   int   m_state = 0;  // 0 idle, 1 emitting, 2 done
   bit   m_err   = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0;
         m_err   = 1'b0;
         q.delete();
      end else begin
         case (m_state)
            0: if (in_valid) begin
               logic [LANES-1:0] m;
               logic [ADDR_W-1:0] base;
               int i;
               m    = in_strb_use ? in_strb : '1;
               base = in_addr & ~ADDR_W'(LANES - 1);
               m_err = 1'b0;
               i = 0;
               while (i < LANES) begin
                  if (m[i]) begin
                     cmd_t c;
                     int s;
                     s = i;
                     while (i < LANES && m[i]) i++;
                     c.a = base + ADDR_W'(s);
                     c.l = i - s;
                     c.d = '0;
                     for (int j = 0; j < c.l; j++) c.d[j*8 +: 8] = in_data[(s+j)*8 +: 8];
                     q.push_back(c);
                  end else begin
                     i++;
                  end
               end
               m_state = (q.size() == 0) ? 2 : 1;
            end
            1: if (out_ready) begin
               if (cmd_err) m_err = 1'b1;
               void'(q.pop_front());
               if (q.size() == 0) m_state = 2;
            end
            default: m_state = 0;
         endcase
      end
   end

   // ------------- per-cycle comparison and downstream driver -------------
   bit                hold_prev = 1'b0;
   logic [ADDR_W-1:0] h_addr;
   logic [LEN_W-1:0]  h_len;
   logic [63:0]       h_data;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (hold_prev) begin
            chk(out_valid && out_addr == h_addr && out_len == h_len && out_data == h_data,
                "R8 stalled payload held", {out_len, out_addr}, {h_len, h_addr});
         end
         chk(in_ready == (m_state == 0), "R2 in_ready", in_ready, m_state == 0);
         chk(out_valid == (m_state == 1), "R3 out_valid", out_valid, m_state == 1);
         chk(done == (m_state == 2), "R9 done", done, m_state == 2);
         if (m_state == 1 && out_valid) begin
            chk(out_len == LEN_W'(q[0].l), "R3 run length", out_len, q[0].l);
            chk(out_addr == q[0].a, "R4 run address", out_addr, q[0].a);
            chk(out_data == q[0].d, "R5 packed data", out_data, q[0].d);
         end
         if (m_state == 2) chk(done_err == m_err, "R10 done_err", done_err, m_err);
         else              chk(!done_err, "R10 done_err outside done", done_err, 0);
         if (out_valid) begin
            word_valid_cycles++;
            if (first_len < 0) first_len = int'(out_len);
         end
         // downstream stimulus for the coming edge
         case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 4) != 0;
            default: out_ready = (cyc % 4) == 0;
         endcase
         cmd_err = (err_mode == 1) ? (($urandom % 3) == 0) : 1'b0;
         hold_prev = out_valid && !out_ready;
         h_addr = out_addr;
         h_len  = out_len;
         h_data = out_data;
      end
   end

   task automatic send_word(input logic [ADDR_W-1:0] a, input logic [63:0] d,
                            input logic [LANES-1:0] s, input bit use_s);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_addr = a; in_data = d; in_strb = s; in_strb_use = use_s;
      in_valid = 1'b1;
      word_valid_cycles = 0;
      first_len = -1;
      @(negedge clk);
      in_valid = 1'b0;
      in_strb  = ~s;       // disturb inputs while busy
      in_data  = ~d;
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(in_ready && !out_valid && !done && !done_err, "R1 reset state",
          {in_ready, out_valid, done, done_err}, 4'b1000);

      send_word(16'h0100, 64'h8877665544332211, 8'b0011_0110, 1'b1);
      send_word(16'h0208, 64'h0123456789ABCDEF, 8'hFF, 1'b1);

      send_word(16'h0310, 64'hDEADBEEFCAFEF00D, 8'h05, 1'b0);
      chk(first_len == LANES && word_valid_cycles == 1, "R6 strobe unused gives one full run",
          first_len, LANES);

      send_word(16'h0418, 64'h1111111111111111, 8'h00, 1'b1);
      chk(word_valid_cycles == 0, "R7 empty strobe gives no command", word_valid_cycles, 0);

      send_word(16'h0520, 64'hA0B0C0D0E0F01020, 8'b1000_0001, 1'b1);   // R3 top lane closure

      ready_mode = 2;
      send_word(16'h0628, 64'h0F1E2D3C4B5A6978, 8'b1010_1010, 1'b1);   // R8 stall
      chk(word_valid_cycles > 4, "R8 stall stretched commands", word_valid_cycles, 5);

      ready_mode = 1; err_mode = 1;
      send_word(16'h0730, 64'h5566778899AABBCC, 8'b1110_0111, 1'b1);   // R10
      err_mode = 0;
      send_word(16'h1235, 64'h0102030405060708, 8'b0111_1100, 1'b1);   // R4 low bits dropped

      for (int k = 0; k < 60; k++) begin
         err_mode = k % 2;
         send_word(ADDR_W'($urandom), {$urandom, $urandom}, LANES'($urandom), (k % 7) != 3);
      end

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule